// File: doc/BRIEF.md
# Speculative Load Check Table

This block lets a scheduler hoist a load above earlier stores whose addresses are still unknown. When such an early load issues, it records its destination register, its byte address and its access width in a small fully associative table. Each store that follows searches every entry at once and removes any entry whose bytes it may have written. When the program reaches the load's original position, a check on the same destination register asks whether an entry survived. A hit means the early value is still good. A miss means recovery code must run.

Overlap is decided on 8-byte granules. A store and a recorded load collide when the span of granules touched by one meets the span touched by the other. This can over-report a collision, but it never misses a real one. The memory access itself and the recovery path are outside this block. A flush input drops every entry, for example on a context switch.

Top module: `ldspec_table`

## Requirements
- R1: After reset the table holds no entry. `checkRespValid` stays low until a check is issued, and any check misses.
- R2: An allocation on register r followed by a check on r reports a hit. `checkRespValid` and `checkRespHit` are valid in the cycle after the check request.
- R3: A check on a register with no valid entry reports a miss.
- R4: Sizes are encoded as log2 of the byte count (0 means 1 byte, 3 means 8 bytes). A store removes an entry when the granule spans overlap, where a span runs from addr>>3 to (addr+bytes-1)>>3. A store whose span does not overlap leaves the entry in place.
- R5: An unaligned access that crosses an 8-byte boundary covers both granules, and a store to either granule removes it.
- R6: An allocation for a register that already has a valid entry replaces that entry. After it, a store to the old address no longer affects the register.
- R7: An allocation for a new register takes the lowest-indexed free entry. When the table is full, it replaces the entry at a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, only on such a replacement.
- R8: A check that hits leaves the entry in place, so a repeated check hits again.
- R9: Flush clears all entries in one cycle and takes priority over an allocation in the same cycle. A check in the same cycle as a flush misses.
- R10: When an allocation and an overlapping store arrive in the same cycle, the store is treated as older and the new entry stays valid.
- R11: When a check and an overlapping store to that register's entry arrive in the same cycle, the store acts first and the check misses.
- R12: `checkRespValid` is high in exactly those cycles that directly follow a cycle with `checkValid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop every entry |
| allocValid | input | 1 | Record an early load this cycle |
| allocReg | input | 7 | Destination register of the early load |
| allocAddr | input | 64 | Byte address of the early load |
| allocSize | input | 2 | log2 of the early load's byte count |
| snoopValid | input | 1 | A store is presented this cycle |
| snoopAddr | input | 64 | Store byte address |
| snoopSize | input | 2 | log2 of the store's byte count |
| checkValid | input | 1 | Check request this cycle |
| checkReg | input | 7 | Register being checked |
| checkRespValid | output | 1 | Check result is valid (one cycle after the request) |
| checkRespHit | output | 1 | 1: entry survived; 0: recovery needed |

## Verification
Any corruption inside the table shows up only at a later check, so the bench pairs every allocation and store pattern with checks. A stale valid bit, a wrong victim index, a missed overlap or a wrong same-cycle ordering turns into a flipped `checkRespHit` on the next check of the affected register, one cycle after that check is issued. A reference model of valid bits, tags and the round-robin pointer follows each step. Directed fills push the table through several replacement cycles, and a long pseudo-random run over a narrow address window forces frequent overlaps, duplicate registers and evictions, so that a hidden error surfaces within a few cycles.

// File: rtl/ldspec_pkg.sv
package ldspec_pkg;

  parameter int unsigned DEF_ENTRIES = 16;
  parameter int unsigned DEF_TAG_W   = 7;
  parameter int unsigned DEF_ADDR_W  = 64;
  parameter int unsigned DEF_SIZE_W  = 2;
  parameter int unsigned DEF_GRAN_LG = 3;

  // Strobes from control into the entry storage
  typedef struct packed {
    logic wrEn;    // write the selected entry and mark it valid
    logic clrAll;  // drop every valid bit
  } tblStrobe_t;

endpackage

// File: rtl/ldspec_store.sv
module ldspec_store
  import ldspec_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned TAG_W   = DEF_TAG_W,
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned SIZE_W  = DEF_SIZE_W,
  parameter int unsigned GRAN_LG = DEF_GRAN_LG,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tblStrobe_t         strobe,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [ENTRIES-1:0] killVec,
  input  logic [TAG_W-1:0]   allocReg,
  input  logic [ADDR_W-1:0]  allocAddr,
  input  logic [SIZE_W-1:0]  allocSize,
  input  logic [ADDR_W-1:0]  snoopAddr,
  input  logic [SIZE_W-1:0]  snoopSize,
  input  logic [TAG_W-1:0]   checkReg,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] allocHitVec,
  output logic [ENTRIES-1:0] checkHitVec,
  output logic [ENTRIES-1:0] snoopHitVec
);

  localparam int unsigned GRAN_W = ADDR_W - GRAN_LG;
  localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ENTRIES-1:0] ONE_E = {{(ENTRIES-1){1'b0}}, 1'b1};

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ  [ENTRIES];
  logic [ADDR_W-1:0]  addrQ [ENTRIES];
  logic [SIZE_W-1:0]  sizeQ [ENTRIES];

  logic [ADDR_W-1:0]  snoopEnd;
  logic [GRAN_W-1:0]  snoopFirst;
  logic [GRAN_W-1:0]  snoopLast;
  logic [ENTRIES-1:0] wrOneHot;

  assign snoopEnd   = snoopAddr + (ONE_A << snoopSize) - ONE_A;
  assign snoopFirst = snoopAddr[ADDR_W-1:GRAN_LG];
  assign snoopLast  = snoopEnd[ADDR_W-1:GRAN_LG];
  assign wrOneHot   = ONE_E << wrIdx;
  assign validVec   = validQ;

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    logic [ADDR_W-1:0] entEnd;
    logic [GRAN_W-1:0] entFirst;
    logic [GRAN_W-1:0] entLast;

    assign entEnd   = addrQ[e] + (ONE_A << sizeQ[e]) - ONE_A;
    assign entFirst = addrQ[e][ADDR_W-1:GRAN_LG];
    assign entLast  = entEnd[ADDR_W-1:GRAN_LG];

    assign snoopHitVec[e] = validQ[e] && (snoopFirst <= entLast) && (entFirst <= snoopLast);
    assign allocHitVec[e] = validQ[e] && (tagQ[e] == allocReg);
    assign checkHitVec[e] = validQ[e] && (tagQ[e] == checkReg);

    always_ff @(posedge clk) begin
      if (strobe.wrEn && (wrIdx == IDX_W'(e))) begin
        tagQ[e]  <= allocReg;
        addrQ[e] <= allocAddr;
        sizeQ[e] <= allocSize;
      end
    end
  end

  // Kills apply before the write, so a same-cycle allocation survives
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrAll) begin
      validQ <= '0;
    end else begin
      validQ <= (validQ & ~killVec) | (strobe.wrEn ? wrOneHot : '0);
    end
  end

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAll |=> (validQ == '0));

  // R10
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> validQ[$past(wrIdx)]);

  // R6
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(allocHitVec) <= 1);

endmodule

// File: rtl/ldspec_ctrl.sv
module ldspec_ctrl
  import ldspec_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               allocValid,
  input  logic               snoopValid,
  input  logic               checkValid,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] allocHitVec,
  input  logic [ENTRIES-1:0] checkHitVec,
  input  logic [ENTRIES-1:0] snoopHitVec,
  output tblStrobe_t         strobe,
  output logic [IDX_W-1:0]   wrIdx,
  output logic [ENTRIES-1:0] killVec,
  output logic               checkRespValid,
  output logic               checkRespHit
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] hitIdx;
  logic [IDX_W-1:0] freeIdx;
  logic             anyAllocHit;
  logic             tableFull;
  logic             evict;
  logic             checkHitNow;

  assign killVec     = snoopValid ? snoopHitVec : '0;
  assign anyAllocHit = |allocHitVec;
  assign tableFull   = &validVec;

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (allocHitVec[i]) hitIdx = IDX_W'(i);
    end
  end

  // Scan downward so the lowest free index wins
  always_comb begin
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = IDX_W'(i);
    end
  end

  assign wrIdx = anyAllocHit ? hitIdx : (tableFull ? rrPtr : freeIdx);
  assign evict = allocValid && !flush && !anyAllocHit && tableFull;

  assign strobe.wrEn   = allocValid && !flush;
  assign strobe.clrAll = flush;

  assign checkHitNow = checkValid && !flush && (|(checkHitVec & ~killVec));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (evict) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      checkRespValid <= 1'b0;
      checkRespHit   <= 1'b0;
    end else begin
      checkRespValid <= checkValid;
      checkRespHit   <= checkHitNow;
    end
  end

  // R12
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    checkValid |=> checkRespValid);

  // R12
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !checkValid |=> !checkRespValid);

  // R11
  store_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (checkValid && snoopValid && (|(checkHitVec & snoopHitVec))) |=> !checkRespHit);

  // R7
  free_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && !flush && !anyAllocHit && !tableFull) |-> !validVec[wrIdx]);

endmodule

// File: rtl/ldspec_table.sv
module ldspec_table
  import ldspec_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned TAG_W   = DEF_TAG_W,
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned SIZE_W  = DEF_SIZE_W,
  parameter int unsigned GRAN_LG = DEF_GRAN_LG
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              allocValid,
  input  logic [TAG_W-1:0]  allocReg,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic [SIZE_W-1:0] allocSize,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic [SIZE_W-1:0] snoopSize,
  input  logic              checkValid,
  input  logic [TAG_W-1:0]  checkReg,
  output logic              checkRespValid,
  output logic              checkRespHit
);

  localparam int unsigned IDX_W = $clog2(ENTRIES);

  tblStrobe_t         strobe;
  logic [IDX_W-1:0]   wrIdx;
  logic [ENTRIES-1:0] killVec;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] allocHitVec;
  logic [ENTRIES-1:0] checkHitVec;
  logic [ENTRIES-1:0] snoopHitVec;

  ldspec_store #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .ADDR_W  (ADDR_W),
    .SIZE_W  (SIZE_W),
    .GRAN_LG (GRAN_LG)
  ) u_store (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrIdx       (wrIdx),
    .killVec     (killVec),
    .allocReg    (allocReg),
    .allocAddr   (allocAddr),
    .allocSize   (allocSize),
    .snoopAddr   (snoopAddr),
    .snoopSize   (snoopSize),
    .checkReg    (checkReg),
    .validVec    (validVec),
    .allocHitVec (allocHitVec),
    .checkHitVec (checkHitVec),
    .snoopHitVec (snoopHitVec)
  );

  ldspec_ctrl #(
    .ENTRIES (ENTRIES)
  ) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .flush          (flush),
    .allocValid     (allocValid),
    .snoopValid     (snoopValid),
    .checkValid     (checkValid),
    .validVec       (validVec),
    .allocHitVec    (allocHitVec),
    .checkHitVec    (checkHitVec),
    .snoopHitVec    (snoopHitVec),
    .strobe         (strobe),
    .wrIdx          (wrIdx),
    .killVec        (killVec),
    .checkRespValid (checkRespValid),
    .checkRespHit   (checkRespHit)
  );

endmodule

// File: tb/ldspec_table_tb.sv
`timescale 1ns/1ps
module ldspec_table_tb;

  localparam int ENT = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        allocValid = 1'b0;
  logic [6:0]  allocReg = '0;
  logic [63:0] allocAddr = '0;
  logic [1:0]  allocSize = '0;
  logic        snoopValid = 1'b0;
  logic [63:0] snoopAddr = '0;
  logic [1:0]  snoopSize = '0;
  logic        checkValid = 1'b0;
  logic [6:0]  checkReg = '0;
  logic        checkRespValid;
  logic        checkRespHit;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  // reference model
  bit          mValid [ENT];
  logic [6:0]  mReg   [ENT];
  logic [63:0] mAddr  [ENT];
  logic [1:0]  mSize  [ENT];
  int          mRr = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  ldspec_table u_dut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .allocValid(allocValid), .allocReg(allocReg), .allocAddr(allocAddr), .allocSize(allocSize),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr), .snoopSize(snoopSize),
    .checkValid(checkValid), .checkReg(checkReg),
    .checkRespValid(checkRespValid), .checkRespHit(checkRespHit)
  );

  function automatic bit ovl(logic [63:0] a1, logic [1:0] s1, logic [63:0] a2, logic [1:0] s2);
    logic [63:0] e1 = a1 + (64'd1 << s1) - 64'd1;
    logic [63:0] e2 = a2 + (64'd1 << s2) - 64'd1;
    return ((a1 >> 3) <= (e2 >> 3)) && ((a2 >> 3) <= (e1 >> 3));
  endfunction

  task automatic report(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle of traffic; inputs driven at a falling edge, result sampled at the next one
  task automatic step(input bit aV, input logic [6:0] aR, input logic [63:0] aA, input logic [1:0] aS,
                      input bit sV, input logic [63:0] sA, input logic [1:0] sS,
                      input bit cV, input logic [6:0] cR, input bit fl, input string tag);
    bit expHit = 1'b0;
    int hitI = -1;
    int freeI = -1;
    int wI;
    allocValid = aV; allocReg = aR; allocAddr = aA; allocSize = aS;
    snoopValid = sV; snoopAddr = sA; snoopSize = sS;
    checkValid = cV; checkReg = cR; flush = fl;
    if (cV && !fl) begin
      for (int e = 0; e < ENT; e++)
        if (mValid[e] && mReg[e] == cR && !(sV && ovl(mAddr[e], mSize[e], sA, sS))) expHit = 1'b1;
    end
    if (fl) begin
      for (int e = 0; e < ENT; e++) mValid[e] = 1'b0;
    end else begin
      for (int e = 0; e < ENT; e++) begin
        if (mValid[e] && mReg[e] == aR) hitI = e;
        if (!mValid[e] && freeI < 0) freeI = e;
      end
      if (sV) begin
        for (int e = 0; e < ENT; e++)
          if (mValid[e] && ovl(mAddr[e], mSize[e], sA, sS)) mValid[e] = 1'b0;
      end
      if (aV) begin
        wI = (hitI >= 0) ? hitI : ((freeI >= 0) ? freeI : mRr);
        if (hitI < 0 && freeI < 0) mRr = (mRr + 1) % ENT;
        mValid[wI] = 1'b1; mReg[wI] = aR; mAddr[wI] = aA; mSize[wI] = aS;
      end
    end
    @(posedge clk);
    @(negedge clk);
    allocValid = 1'b0; snoopValid = 1'b0; checkValid = 1'b0; flush = 1'b0;
    if (cV) begin
      report(checkRespValid === 1'b1 && checkRespHit === expHit, tag,
             int'({checkRespValid, checkRespHit}), int'({1'b1, expHit}));
    end else begin
      report(checkRespValid === 1'b0, {tag, " (R12 idle)"}, int'(checkRespValid), 0);
    end
  endtask

  task automatic alloc(input logic [6:0] r, input logic [63:0] a, input logic [1:0] s, input string tag);
    step(1, r, a, s, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic snoop(input logic [63:0] a, input logic [1:0] s, input string tag);
    step(0, 0, 0, 0, 1, a, s, 0, 0, 0, tag);
  endtask
  task automatic chk(input logic [6:0] r, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, r, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R12: watchdog expired, actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < ENT; e++) mValid[e] = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle response after reset, then a miss
    report(checkRespValid === 1'b0, "R1 resp after reset", int'(checkRespValid), 0);
    chk(7'd5, "R1");
    // R2 / R8
    alloc(7'd1, 64'h100, 2'd3, "R2");
    chk(7'd1, "R2");
    chk(7'd1, "R8");
    // R3
    chk(7'd2, "R3");
    // R4: neighbour granule untouched, then a 1-byte store inside
    snoop(64'h108, 2'd3, "R4");
    chk(7'd1, "R4");
    snoop(64'h104, 2'd0, "R4");
    chk(7'd1, "R4");
    // R5: 4 bytes at 0x1FE span two granules
    alloc(7'd3, 64'h1FE, 2'd2, "R5");
    chk(7'd3, "R5");
    snoop(64'h200, 2'd0, "R5");
    chk(7'd3, "R5");
    // R6
    alloc(7'd4, 64'h300, 2'd3, "R6");
    alloc(7'd4, 64'h400, 2'd3, "R6");
    snoop(64'h300, 2'd3, "R6");
    chk(7'd4, "R6");
    snoop(64'h400, 2'd3, "R6");
    chk(7'd4, "R6");
    // R10
    step(1, 7'd5, 64'h500, 2'd3, 1, 64'h500, 2'd3, 0, 0, 0, "R10");
    chk(7'd5, "R10");
    // R11
    alloc(7'd6, 64'h600, 2'd3, "R11");
    step(0, 0, 0, 0, 1, 64'h600, 2'd3, 1, 7'd6, 0, "R11");
    chk(7'd6, "R11");
    // R9
    alloc(7'd7, 64'h700, 2'd3, "R9");
    step(1, 7'd8, 64'h800, 2'd3, 0, 0, 0, 1, 7'd7, 1, "R9");
    chk(7'd7, "R9");
    chk(7'd8, "R9");
    chk(7'd5, "R9");
    // R7: fill, evict twice, free slot reuse, evict again
    for (int r = 10; r < 26; r++) alloc(7'(r), 64'(r) * 64'h40, 2'd3, "R7");
    for (int r = 10; r < 26; r++) chk(7'(r), "R7");
    alloc(7'd40, 64'h2000, 2'd3, "R7");
    chk(7'd10, "R7");
    chk(7'd40, "R7");
    chk(7'd11, "R7");
    alloc(7'd41, 64'h2100, 2'd3, "R7");
    chk(7'd11, "R7");
    chk(7'd12, "R7");
    snoop(64'd15 * 64'h40, 2'd3, "R7");
    alloc(7'd42, 64'h2200, 2'd3, "R7");
    alloc(7'd43, 64'h2300, 2'd3, "R7");
    chk(7'd12, "R7");
    chk(7'd13, "R7");
    chk(7'd42, "R7");
    chk(7'd43, "R7");
    // Mixed traffic over a narrow window (R4 overlaps, R7 evictions)
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] x;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      x = lfsr;
      step(x[0], 7'(x[8:4] % 24), {57'd0, x[15:9]}, x[17:16],
           x[1] & x[2], {57'd0, x[24:18]}, x[26:25],
           x[3] | x[27], 7'((x[31:28] + x[8:4]) % 24), (x[15:8] == 8'd0), "R4");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule